// File: doc/BRIEF.md
# Interrupt Vector Priority Router

This block sits between the channel interrupt sources and a bank of eight interrupt queues. Each incoming 32-bit channel interrupt vector carries the index of the regular queue its channel belongs to. The block checks the vector against a per-queue high-priority mask. It then pushes the vector to the fixed high-priority queue, to its own regular queue, or to both. A vector with no bits set is discarded.

Each of the regular queues 0 to 6 has its own 32-bit mask. Software loads a mask in two steps. It first writes a shared staging register. It then writes a command that names a target queue and carries a commit flag, which copies the staged value into that queue's mask. Vectors enter through a valid/ready handshake. Pushes leave through a second valid/ready handshake that carries a queue index and the vector.

Top module: `irq_prio_router`

## Requirements
- R1: After reset the staging register and all seven per-queue masks are zero, out_valid_o is 0 and in_ready_o is 1, so every nonzero vector goes only to its own queue.
- R2: A write to address 0xEC loads the staging register. Whenever reg_addr_i equals 0xEC, reg_rdata_o returns the staged value. Any other address reads zero.
- R3: A write to address 0xF0 with bit 8 set copies the staging register into the mask of the queue in bits [2:0]. The copy takes effect on the cycle after the write. A vector accepted in the same cycle as that write is routed with the old mask. A write to 0xF0 with bit 8 clear changes no mask.
- R4: A commit naming queue 7 leaves every mask unchanged.
- R5: An accepted vector is pushed with queue index 7 when at least one of its set bits is also set in its queue's mask.
- R6: An accepted vector is pushed with its own queue index when at least one of its set bits is clear in its queue's mask. A vector tagged with queue 7 uses an all-zero mask, so it is pushed once, to queue 7.
- R7: When both R5 and R6 apply, the queue-7 push comes first and the regular push follows on the next cycle in which out_ready_i is high. in_ready_o stays low until both pushes are accepted.
- R8: An accepted all-zero vector produces no push.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o, out_queue_o and out_vec_o hold their values.
- R10: in_ready_o is low in every cycle in which out_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address (0xEC staging, 0xF0 commit command) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Staging register readback when the address is 0xEC |
| in_valid_i | input | 1 | Input vector valid |
| in_ready_o | output | 1 | Input vector accepted when high together with valid |
| in_queue_i | input | 3 | Regular queue of the vector's channel |
| in_vec_i | input | 32 | Channel interrupt vector |
| out_valid_o | output | 1 | Push request valid |
| out_ready_i | input | 1 | Queue side accepts the push |
| out_queue_o | output | 3 | Target queue of the push |
| out_vec_o | output | 32 | Vector being pushed |

## Verification
A mask loaded into the wrong queue, or loaded a cycle early or late, shows up on the first vector routed through that queue. That vector is pushed to queue 7 when it should not be, is missing from queue 7 when it should be there, or is pushed a second time to its own queue. A broken push sequencer shows within one or two cycles of the vector being accepted. The symptoms are a wrong push order, a missing or doubled push, a push of an empty vector, or in_ready_o rising while a push is still pending. A vector offered together with a commit tells apart a mask update that lands in the write cycle from one that lands in the cycle after.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned NUM_Q      = 8;
  localparam int unsigned VEC_W      = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned STAGE_ADDR = 'hEC;
  localparam int unsigned CMD_ADDR   = 'hF0;
  localparam int unsigned COMMIT_BIT = 8;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_HP   = 2'd1,
    PS_REG  = 2'd2
  } push_state_e;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_Q      = 8,
  parameter int unsigned VEC_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STAGE_ADDR = 'hEC,
  parameter int unsigned CMD_ADDR   = 'hF0,
  parameter int unsigned COMMIT_BIT = 8,
  localparam int unsigned QIDX_W    = $clog2(NUM_Q),
  localparam int unsigned NUM_REG_Q = NUM_Q - 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [VEC_W-1:0]           wdata_i,
  output logic [VEC_W-1:0]           stage_o,
  output logic [NUM_REG_Q*VEC_W-1:0] mask_flat_o
);
  logic              stage_hit, cmd_hit;
  logic [QIDX_W-1:0] cmd_q;
  logic [VEC_W-1:0]  stage_q;

  assign stage_hit = we_i && (addr_i == ADDR_W'(STAGE_ADDR));
  assign cmd_hit   = we_i && (addr_i == ADDR_W'(CMD_ADDR)) && wdata_i[COMMIT_BIT];
  assign cmd_q     = wdata_i[QIDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else if (stage_hit) stage_q <= wdata_i;
  end
  assign stage_o = stage_q;

  // the high-priority queue index never matches a slot, so its commit is dropped
  for (genvar g = 0; g < NUM_REG_Q; g++) begin : g_mask
    logic [VEC_W-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else if (cmd_hit && (cmd_q == QIDX_W'(g))) mask_q <= stage_q;
    end
    assign mask_flat_o[g*VEC_W +: VEC_W] = mask_q;
  end
endmodule

// File: rtl/irq_route_dec.sv
module irq_route_dec #(
  parameter int unsigned NUM_Q      = 8,
  parameter int unsigned VEC_W      = 32,
  localparam int unsigned QIDX_W    = $clog2(NUM_Q),
  localparam int unsigned NUM_REG_Q = NUM_Q - 1
) (
  input  logic [VEC_W-1:0]           vec_i,
  input  logic [QIDX_W-1:0]          queue_i,
  input  logic [NUM_REG_Q*VEC_W-1:0] mask_flat_i,
  output logic                       to_hp_o,
  output logic                       to_reg_o
);
  logic [VEC_W-1:0] mask_sel;

  always_comb begin
    mask_sel = '0;
    for (int i = 0; i < NUM_REG_Q; i++) begin
      if (queue_i == QIDX_W'(i)) mask_sel = mask_flat_i[i*VEC_W +: VEC_W];
    end
  end

  assign to_hp_o  = |(vec_i & mask_sel);
  assign to_reg_o = |(vec_i & ~mask_sel);
endmodule

// File: rtl/irq_push_seq.sv
module irq_push_seq
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_Q   = 8,
  parameter int unsigned VEC_W   = 32,
  localparam int unsigned QIDX_W = $clog2(NUM_Q),
  localparam int unsigned HP_Q   = NUM_Q - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [QIDX_W-1:0] in_queue_i,
  input  logic [VEC_W-1:0]  in_vec_i,
  input  logic              to_hp_i,
  input  logic              to_reg_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [QIDX_W-1:0] out_queue_o,
  output logic [VEC_W-1:0]  out_vec_o
);
  push_state_e       state_q;
  logic [QIDX_W-1:0] queue_q;
  logic [VEC_W-1:0]  vec_q;
  logic              reg_pend_q;
  logic              accept;

  assign in_ready_o = (state_q == PS_IDLE);
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PS_IDLE;
      queue_q    <= '0;
      vec_q      <= '0;
      reg_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        PS_IDLE: if (accept) begin
          queue_q    <= in_queue_i;
          vec_q      <= in_vec_i;
          reg_pend_q <= to_reg_i;
          if (to_hp_i)       state_q <= PS_HP;
          else if (to_reg_i) state_q <= PS_REG;
        end
        PS_HP: if (out_ready_i) state_q <= reg_pend_q ? PS_REG : PS_IDLE;
        PS_REG: if (out_ready_i) state_q <= PS_IDLE;
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign out_valid_o = (state_q != PS_IDLE);
  assign out_queue_o = (state_q == PS_HP) ? QIDX_W'(HP_Q) : queue_q;
  assign out_vec_o   = vec_q;
endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_Q      = irq_router_pkg::NUM_Q,
  parameter int unsigned VEC_W      = irq_router_pkg::VEC_W,
  parameter int unsigned ADDR_W     = irq_router_pkg::ADDR_W,
  parameter int unsigned STAGE_ADDR = irq_router_pkg::STAGE_ADDR,
  parameter int unsigned CMD_ADDR   = irq_router_pkg::CMD_ADDR,
  parameter int unsigned COMMIT_BIT = irq_router_pkg::COMMIT_BIT,
  localparam int unsigned QIDX_W    = $clog2(NUM_Q),
  localparam int unsigned NUM_REG_Q = NUM_Q - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [VEC_W-1:0]  reg_wdata_i,
  output logic [VEC_W-1:0]  reg_rdata_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [QIDX_W-1:0] in_queue_i,
  input  logic [VEC_W-1:0]  in_vec_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [QIDX_W-1:0] out_queue_o,
  output logic [VEC_W-1:0]  out_vec_o
);
  logic [VEC_W-1:0]           stage_w;
  logic [NUM_REG_Q*VEC_W-1:0] mask_flat_w;
  logic                       to_hp_w, to_reg_w;

  irq_mask_bank #(
    .NUM_Q(NUM_Q), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
    .STAGE_ADDR(STAGE_ADDR), .CMD_ADDR(CMD_ADDR), .COMMIT_BIT(COMMIT_BIT)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .stage_o(stage_w), .mask_flat_o(mask_flat_w)
  );

  assign reg_rdata_o = (reg_addr_i == ADDR_W'(STAGE_ADDR)) ? stage_w : '0;

  irq_route_dec #(.NUM_Q(NUM_Q), .VEC_W(VEC_W)) u_dec (
    .vec_i(in_vec_i), .queue_i(in_queue_i), .mask_flat_i(mask_flat_w),
    .to_hp_o(to_hp_w), .to_reg_o(to_reg_w)
  );

  irq_push_seq #(.NUM_Q(NUM_Q), .VEC_W(VEC_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_queue_i(in_queue_i), .in_vec_i(in_vec_i),
    .to_hp_i(to_hp_w), .to_reg_i(to_reg_w),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_queue_o(out_queue_o), .out_vec_o(out_vec_o)
  );
endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk #(
  parameter int unsigned NUM_Q      = 8,
  parameter int unsigned VEC_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STAGE_ADDR = 'hEC,
  parameter int unsigned CMD_ADDR   = 'hF0,
  parameter int unsigned COMMIT_BIT = 8,
  localparam int unsigned QIDX_W    = $clog2(NUM_Q),
  localparam int unsigned NUM_REG_Q = NUM_Q - 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       reg_we_i,
  input logic [ADDR_W-1:0]          reg_addr_i,
  input logic [VEC_W-1:0]           reg_wdata_i,
  input logic                       in_ready_o,
  input logic                       out_valid_o,
  input logic                       out_ready_i,
  input logic [QIDX_W-1:0]          out_queue_o,
  input logic [VEC_W-1:0]           out_vec_o,
  input logic [VEC_W-1:0]           stage_w,
  input logic [NUM_REG_Q*VEC_W-1:0] mask_flat_w
);
  logic cmd_commit, cmd_to_hp;
  assign cmd_commit = reg_we_i && (reg_addr_i == ADDR_W'(CMD_ADDR)) && reg_wdata_i[COMMIT_BIT];
  assign cmd_to_hp  = reg_wdata_i[QIDX_W-1:0] == QIDX_W'(NUM_Q - 1);

  a_r3_commit_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_commit && !cmd_to_hp |=>
      mask_flat_w[$past(reg_wdata_i[QIDX_W-1:0])*VEC_W +: VEC_W] == $past(stage_w));

  a_r4_hp_commit_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_commit && cmd_to_hp |=> $stable(mask_flat_w));

  a_r8_no_empty_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_vec_o != '0);

  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_queue_o) && $stable(out_vec_o));

  a_r10_busy_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
endmodule

bind irq_prio_router irq_prio_router_chk #(
  .NUM_Q(NUM_Q), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
  .STAGE_ADDR(STAGE_ADDR), .CMD_ADDR(CMD_ADDR), .COMMIT_BIT(COMMIT_BIT)
) u_chk (.*);

// File: tb/irq_prio_router_test.sv
module irq_prio_router_test;
  localparam time CLK_PERIOD = 10;
  localparam logic [7:0] A_STAGE = 8'hEC;
  localparam logic [7:0] A_CMD   = 8'hF0;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        in_valid = 1'b0, in_ready;
  logic [2:0]  in_queue = '0;
  logic [31:0] in_vec = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [2:0]  out_queue;
  logic [31:0] out_vec;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_stage = '0;
  logic [31:0] m_mask [8];

  irq_prio_router uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_queue_i(in_queue), .in_vec_i(in_vec),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_queue_o(out_queue), .out_vec_o(out_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    if (a == A_STAGE) m_stage = d;
    if (a == A_CMD && d[8] && d[2:0] != 3'd7) m_mask[d[2:0]] = m_stage;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
    model_write(a, d);
  endtask

  // samples pushes at negedges, starting at the negedge right after acceptance
  task automatic collect_check(input string req, input logic [2:0] q, input logic [31:0] v,
                               input logic [31:0] m);
    logic [2:0]  qs [3];
    logic [31:0] vs [3];
    int n = 0;
    bit hp, rg;
    int exp_n;
    hp = |(v & m);
    rg = |(v & ~m);
    exp_n = int'(hp) + int'(rg);
    for (int k = 0; k < 3; k++) begin
      if (out_valid) begin
        chk(!in_ready, "R10 in_ready low while pushing", {31'd0, in_ready}, 32'd0);
        if (n < 3) begin qs[n] = out_queue; vs[n] = out_vec; end
        n++;
      end
      @(negedge clk);
    end
    chk(n == exp_n, {req, " push count"}, n, exp_n);
    if (n == exp_n && n > 0) begin
      chk(qs[0] == (hp ? 3'd7 : q), {req, " first queue"}, qs[0], hp ? 3'd7 : q);
      chk(vs[0] == v, {req, " first vector"}, vs[0], v);
      if (n == 2) begin
        chk(qs[1] == q, {req, " R7 second queue"}, qs[1], q);
        chk(vs[1] == v, {req, " R7 second vector"}, vs[1], v);
      end
    end
  endtask

  task automatic send(input string req, input logic [2:0] q, input logic [31:0] v);
    logic [31:0] m;
    m = (q == 3'd7) ? 32'd0 : m_mask[q];
    @(negedge clk);
    chk(in_ready, {req, " in_ready idle"}, {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1; in_queue = q; in_vec = v;
    @(negedge clk);
    in_valid = 1'b0;
    collect_check(req, q, v, m);
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    reg_addr = A_STAGE; #1;
    chk(reg_rdata == 32'd0, "R1 staging reset", reg_rdata, 32'd0);
    reg_addr = '0;
    for (int q = 0; q < 7; q++) send("R1 default no forward", 3'(q), 32'hFFFF_FFFF);
  endtask

  task automatic t_stage;
    wr(A_STAGE, 32'hA5A5_0F0F);
    reg_addr = A_STAGE; #1;
    chk(reg_rdata == 32'hA5A5_0F0F, "R2 staging readback", reg_rdata, 32'hA5A5_0F0F);
    reg_addr = 8'h10; #1;
    chk(reg_rdata == 32'd0, "R2 other address reads zero", reg_rdata, 32'd0);
    reg_addr = '0;
  endtask

  task automatic t_route;
    wr(A_STAGE, 32'h0000_00F0);
    wr(A_CMD, 32'h0000_0102);
    send("R5 masked only", 3'd2, 32'h0000_0010);
    send("R6 unmasked only", 3'd2, 32'h0000_0001);
    send("R7 both", 3'd2, 32'h0000_0011);
    send("R6 other queue unaffected", 3'd3, 32'h0000_0010);
    wr(A_STAGE, 32'hFFFF_0000);
    wr(A_CMD, 32'h0000_0003);
    send("R3 no commit bit", 3'd3, 32'h0001_0000);
  endtask

  task automatic t_hp_commit;
    wr(A_STAGE, 32'hFFFF_FFFF);
    wr(A_CMD, 32'h0000_0107);
    for (int q = 0; q < 7; q++) send("R4 queue7 commit ignored", 3'(q), 32'h0000_FFFF);
    send("R6 queue7 tagged", 3'd7, 32'h8000_0001);
  endtask

  task automatic t_zero;
    send("R8 empty vector", 3'd2, 32'd0);
    send("R8 empty vector q0", 3'd0, 32'd0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] old_m;
    wr(A_STAGE, 32'h0000_0001);
    old_m = m_mask[4];
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = 32'h0000_0104;
    in_valid = 1'b1; in_queue = 3'd4; in_vec = 32'h0000_0001;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0; in_valid = 1'b0;
    collect_check("R3 same-cycle uses old mask", 3'd4, 32'h0000_0001, old_m);
    model_write(A_CMD, 32'h0000_0104);
    send("R3 new mask next vector", 3'd4, 32'h0000_0001);
  endtask

  task automatic t_stall;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_queue = 3'd2; in_vec = 32'h0000_0011;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid, "R9 valid held", {31'd0, out_valid}, 32'd1);
      chk(out_queue == 3'd7, "R9 queue held", out_queue, 32'd7);
      chk(out_vec == 32'h11, "R9 vector held", out_vec, 32'h11);
      chk(!in_ready, "R10 in_ready low on stall", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid && out_queue == 3'd2, "R7 regular after stalled hp", out_queue, 32'd2);
    chk(!in_ready, "R7 in_ready low until second push", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk(!out_valid && in_ready, "R7 idle after both pushes", {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_mask[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_route();
    t_hp_commit();
    t_zero();
    t_same_cycle();
    t_stall();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule